// File: doc/BRIEF.md
# Strobe-Handshaked Bus Write Sequencer

This block is the master side of one bus transfer on an asynchronous bus where a slave answers a strobe with an acknowledge. It is clocked at twice the bus clock, so each clock tick is one half-clock state, named S0 to S9. A requester hands over an address, a three-bit function code, write data and two byte-lane selects. The block then walks the bus through the write sequence. It presents the address and function code, raises the address strobe, drives the data, raises the data strobes and waits for the slave's answer. It ends the cycle the short way on acknowledge and the long way on a bus error.

The acknowledge and bus-error inputs arrive asynchronously. Each passes through a two-flop synchronizer before the sequencer uses it. If no answer comes, wait states are added two ticks at a time, and a parameterised limit ends the wait with the bus-error ending. An indivisible read-modify-write mode first runs a read with the address strobe held, then runs a write to the same address without releasing the strobe. The written value is the read value ORed with the request's write data, which acts as a bit-set mask.

All bus strobes on the ports are active high (1 = asserted). Any pin inversion sits outside the block. `bus_rnw` is 1 for read or idle and 0 while a write is driven.

Top module: `wr_cycle_seq`

## Requirements
- R1: While reset is held and after its release, the address strobe and both data strobes are low, `bus_rnw` is 1, `bus_doe` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request is taken only on a clock edge where `req_ready` is 1, and that edge begins S0. A `req_valid` seen while busy is ignored. `bus_addr` and `bus_fc` hold the accepted values from S0 until the cycle ends, and `req_ready` is 0 during that time.
- R3: In a write, `bus_as` and `bus_rnw`=0 appear together at S2 (tick 2 after acceptance). During S0 and S1 the address strobe is low and `bus_rnw` is 1.
- R4: `bus_doe` rises at S3 of a write and stays high through the final state of the cycle. While it is high, `bus_dout` equals the request's write data.
- R5: The data strobes of a write rise at S4. `bus_uds` follows lane bit 1 and `bus_lds` follows lane bit 0.
- R6: Acknowledge and bus error count only after two synchronizer flops, so an input raised during tick a is first usable at tick a+2. S4 is left at the first S4 tick (tick 4, 6, 8, ...) that sees a synchronized termination. Each wait state adds two ticks.
- R7: When acknowledge is seen (with or without bus error), S5 and S6 change nothing. The address and data strobes drop at S7. After S7, `bus_doe` is 0 and `bus_rnw` is 1. `done` pulses for one tick with `done_err`=0.
- R8: When bus error is seen without acknowledge, the strobes stay up through S8 and drop at S9. `bus_doe` and `bus_rnw` are released after S9. `done` pulses with `done_err`=1.
- R9: If MAX_WAITS wait states pass with no termination, the cycle takes the R8 ending and reports `done_err`=1.
- R10: With `req_rmw`=1, a read phase comes first. In that phase `bus_rnw` stays 1, the address and data strobes rise at S2 and `bus_doe` stays 0. The read data is captured at S6 of the read and the data strobes drop at S7. The write phase then starts at once with S0, and `bus_as` stays high throughout. The phase writes `rd_data | req_wdata`, and `rd_data` shows the captured value.
- R11: A bus error during the read phase of a read-modify-write ends the whole operation with the R8 ending. No write phase follows, and `done_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock; one tick per state |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle; a request is taken on this edge |
| req_rmw | input | 1 | 1 selects read-modify-write |
| req_lanes | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| req_fc | input | 3 | Function code for the cycle |
| req_addr | input | AW | Target address |
| req_wdata | input | DW | Write data, or bit-set mask in read-modify-write |
| done | output | 1 | One-tick completion pulse |
| done_err | output | 1 | With done: 1 = bus-error ending |
| rd_data | output | DW | Data captured by the last read phase |
| bus_addr | output | AW | Address bus |
| bus_fc | output | 3 | Function code lines |
| bus_as | output | 1 | Address strobe |
| bus_uds | output | 1 | Upper data strobe |
| bus_lds | output | 1 | Lower data strobe |
| bus_rnw | output | 1 | 1 = read/idle, 0 = write |
| bus_doe | output | 1 | Data bus output enable |
| bus_dout | output | DW | Data driven when enabled |
| bus_din | input | DW | Data returned by the slave |
| bus_ack | input | 1 | Asynchronous data acknowledge |
| bus_berr | input | 1 | Asynchronous bus error |

## Verification
Every bus output is a function of the current state, so the result of a state is visible in the same tick the state is entered. Counting from the acceptance edge as tick 0, the address strobe is due at tick 2, the data output at tick 3 and the write strobes at tick 4. With a termination raised at tick a, the exit tick e is the first even tick that is at least both 4 and a+2. The strobes drop at e+3 on acknowledge or e+5 on bus error, and `done` pulses at e+4 or e+6. The bench computes e from its own schedule of slave responses. It then predicts every output for every tick and compares mid-tick, half a clock away from the edge that changed the state.

// File: rtl/wr_cycle_seq.sv
module wr_cycle_seq #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_WAITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_rmw,
  input  logic [1:0]    req_lanes,
  input  logic [2:0]    req_fc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_fc,
  output logic          bus_as,
  output logic          bus_uds,
  output logic          bus_lds,
  output logic          bus_rnw,
  output logic          bus_doe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ack,
  input  logic          bus_berr
);
  localparam int CW = $clog2(MAX_WAITS + 1);

  typedef enum logic [3:0] {IDLE, S0, S1, S2, S3, S4, SW, S5, S6, S7, S8, S9} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [2:0]    fc_q;
  logic [DW-1:0] wd_q, rd_q;
  logic [1:0]    ln_q, ack_sy, berr_sy;
  logic          rmw_q, wr_q, err_q, done_q, derr_q;
  logic [CW-1:0] wcnt;

  wire ack_s  = ack_sy[1];
  wire berr_s = berr_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sy  <= '0;
      berr_sy <= '0;
    end else begin
      ack_sy  <= {ack_sy[0], bus_ack};
      berr_sy <= {berr_sy[0], bus_berr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; addr_q <= '0; fc_q <= '0; wd_q <= '0; rd_q <= '0; ln_q <= '0;
      rmw_q <= 1'b0; wr_q <= 1'b0; err_q <= 1'b0; wcnt <= '0;
      done_q <= 1'b0; derr_q <= 1'b0;
    end else begin
      done_q <= (st == S7 && !err_q && wr_q) || st == S9;
      derr_q <= st == S9;
      case (st)
        IDLE: if (req_valid) begin
          st <= S0; addr_q <= req_addr; fc_q <= req_fc; wd_q <= req_wdata;
          ln_q <= req_lanes; rmw_q <= req_rmw; wr_q <= !req_rmw;
          err_q <= 1'b0; wcnt <= '0;
        end
        S0: st <= S1;
        S1: st <= S2;
        S2: st <= S3;
        S3: st <= S4;
        S4: begin
          if (ack_s) begin
            st <= S5; err_q <= 1'b0;
          end else if (berr_s || wcnt == CW'(MAX_WAITS)) begin
            st <= S5; err_q <= 1'b1;
          end else begin
            st <= SW; wcnt <= wcnt + 1'b1;
          end
        end
        SW: st <= S4;
        S5: st <= S6;
        S6: begin
          st <= S7;
          if (!wr_q && !err_q) rd_q <= bus_din;
        end
        S7: begin
          if (err_q) st <= S8;
          else if (!wr_q) begin
            st <= S0; wr_q <= 1'b1; wcnt <= '0;
          end else st <= IDLE;
        end
        S8: st <= S9;
        S9: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire in_act   = st inside {S2, S3, S4, SW, S5, S6};
  wire hold_end = err_q && (st == S7 || st == S8);
  wire ds_on    = wr_q ? (st inside {S4, SW, S5, S6} || hold_end) : (in_act || hold_end);
  wire wr_span  = st inside {S3, S4, SW, S5, S6, S7} || (err_q && (st == S8 || st == S9));

  assign req_ready = st == IDLE;
  assign bus_addr  = addr_q;
  assign bus_fc    = fc_q;
  assign bus_as    = in_act || hold_end || (rmw_q && !wr_q && !err_q && st == S7)
                     || (rmw_q && wr_q && (st == S0 || st == S1));
  assign bus_uds   = ds_on & ln_q[1];
  assign bus_lds   = ds_on & ln_q[0];
  assign bus_rnw   = !(wr_q && (st == S2 || wr_span));
  assign bus_doe   = wr_q && wr_span;
  assign bus_dout  = rmw_q ? (rd_q | wd_q) : wd_q;
  assign rd_data   = rd_q;
  assign done      = done_q;
  assign done_err  = derr_q;

  a_r5_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_uds || bus_lds) |-> bus_as);
  a_r4_doe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rnw);
  a_r7_done_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_addr) && $stable(bus_fc));
  a_r10_as_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_q && !wr_q && !err_q && st == S7) |=> (bus_as && !req_ready));
  a_r9_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S4 && wcnt == CW'(MAX_WAITS) && !ack_s) |=> err_q);
endmodule

// File: tb/wr_cycle_seq_tb.sv
module wr_cycle_seq_tb_top;
  localparam int AW = 24, DW = 16, MW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rmw = 1'b0;
  logic [1:0] req_lanes = '0;
  logic [2:0] req_fc = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic bus_ack = 1'b0, bus_berr = 1'b0;
  logic req_ready, done, done_err, bus_as, bus_uds, bus_lds, bus_rnw, bus_doe;
  logic [DW-1:0] rd_data, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [2:0] bus_fc;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;

  wr_cycle_seq #(.AW(AW), .DW(DW), .MAX_WAITS(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rmw(req_rmw), .req_lanes(req_lanes), .req_fc(req_fc), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .done_err(done_err), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_as(bus_as), .bus_uds(bus_uds),
    .bus_lds(bus_lds), .bus_rnw(bus_rnw), .bus_doe(bus_doe), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack(bus_ack), .bus_berr(bus_berr));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // kind: 0 ack, 1 bus error, 2 both, 3 no answer
  function automatic int exit_tick(input int kind, input int a);
    int e;
    if (kind == 3) return 4 + 2 * MW;
    e = (a + 2 < 4) ? 4 : a + 2;
    if (e % 2) e++;
    return e;
  endfunction

  task automatic do_phase(input string tag, input bit wr, input bit rmw, input int kind,
                          input int a, input bit [1:0] ln, input logic [AW-1:0] ad,
                          input logic [2:0] fc, input logic [DW-1:0] wexp,
                          input bit busy_req, output bit err);
    int e, len;
    bit as_e, ds_e, rl_e, oe_e, term;
    e = exit_tick(kind, a);
    err = (kind == 1) || (kind == 3);
    len = err ? e + 6 : e + 4;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      req_valid = busy_req && (t == 2);
      if (busy_req && t == 2) req_addr = ~ad;
      term = (kind != 3) && t >= a && t <= e;
      bus_ack  = term && (kind == 0 || kind == 2);
      bus_berr = term && (kind == 1 || kind == 2);
      as_e = (t >= 2 && (t <= e + 2 || (err && t <= e + 4)))
             || (rmw && !wr && !err && t == e + 3) || (rmw && wr && t < 2);
      ds_e = (t >= (wr ? 4 : 2)) && (t <= e + 2 || (err && t <= e + 4));
      rl_e = wr && t >= 2 && (t <= e + 3 || (err && t <= e + 5));
      oe_e = wr && t >= 3 && (t <= e + 3 || (err && t <= e + 5));
      chk({tag, " R3 as"}, bus_as, as_e);
      chk({tag, " R5 uds"}, bus_uds, ds_e && ln[1]);
      chk({tag, " R5 lds"}, bus_lds, ds_e && ln[0]);
      chk({tag, " R3 rnw"}, bus_rnw, !rl_e);
      chk({tag, " R4 doe"}, bus_doe, oe_e);
      if (oe_e) chk({tag, " R4 dout"}, bus_dout, wexp);
      chk({tag, " R2 addr"}, bus_addr, ad);
      chk({tag, " R2 fc"}, bus_fc, fc);
      chk({tag, " R2 ready"}, req_ready, 1'b0);
      chk({tag, " R7 done"}, done, 1'b0);
    end
  endtask

  task automatic run_op(input string tag, input bit rmw, input bit [1:0] ln, input logic [2:0] fc,
                        input logic [AW-1:0] ad, input logic [DW-1:0] wd, input logic [DW-1:0] din,
                        input int k1, input int a1, input int k2, input int a2, input bit busy_req);
    bit err;
    @(negedge clk);
    req_valid = 1'b1; req_rmw = rmw; req_lanes = ln; req_fc = fc; req_addr = ad;
    req_wdata = wd; bus_din = din;
    do_phase(tag, !rmw, rmw, k1, a1, ln, ad, fc, rmw ? (din | wd) : wd, busy_req, err);
    if (rmw && !err)
      do_phase({tag, " R10 wr"}, 1'b1, 1'b1, k2, a2, ln, ad, fc, din | wd, 1'b0, err);
    @(negedge clk);
    req_valid = 1'b0; bus_ack = 1'b0; bus_berr = 1'b0;
    chk({tag, " R7 done"}, done, 1'b1);
    chk({tag, " R8 done_err"}, done_err, err);
    chk({tag, " R2 ready"}, req_ready, 1'b1);
    chk({tag, " R7 as idle"}, bus_as, 1'b0);
    chk({tag, " R7 rnw idle"}, bus_rnw, 1'b1);
    chk({tag, " R7 doe idle"}, bus_doe, 1'b0);
    if (rmw && k1 != 1 && k1 != 3) chk({tag, " R10 rd_data"}, rd_data, din);
    @(negedge clk);
    chk({tag, " R7 done drop"}, done, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 as in reset", bus_as, 1'b0);
    chk("R1 ds in reset", {bus_uds, bus_lds}, 2'b00);
    chk("R1 rnw in reset", bus_rnw, 1'b1);
    chk("R1 doe in reset", bus_doe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 done", done, 1'b0);
    chk("R1 as", bus_as, 1'b0);
    run_op("R7 ack fast", 1'b0, 2'b11, 3'd5, 24'h12_3456, 16'hA5C3, 16'h0, 0, 1, 0, 0, 1'b0);
    run_op("R6 two waits", 1'b0, 2'b10, 3'd1, 24'h00_0ABC, 16'h1234, 16'h0, 0, 5, 0, 0, 1'b1);
    run_op("R8 berr", 1'b0, 2'b01, 3'd2, 24'hFF_0002, 16'h0F0F, 16'h0, 1, 2, 0, 0, 1'b0);
    run_op("R7 ack+berr", 1'b0, 2'b11, 3'd6, 24'h40_0000, 16'hBEEF, 16'h0, 2, 3, 0, 0, 1'b0);
    run_op("R9 timeout", 1'b0, 2'b11, 3'd5, 24'h00_1000, 16'h5555, 16'h0, 3, 0, 0, 0, 1'b0);
    run_op("R10 rmw", 1'b1, 2'b01, 3'd5, 24'h00_2222, 16'h0080, 16'h0013, 0, 2, 0, 3, 1'b0);
    run_op("R10 rmw waits", 1'b1, 2'b11, 3'd1, 24'h7F_0010, 16'h8000, 16'h00FF, 0, 4, 0, 6, 1'b0);
    run_op("R11 rmw read berr", 1'b1, 2'b10, 3'd2, 24'h00_3333, 16'h0001, 16'h0042, 1, 1, 0, 0, 1'b0);
    run_op("R8 rmw write berr", 1'b1, 2'b11, 3'd5, 24'h00_4444, 16'h0100, 16'h00F0, 0, 1, 1, 2, 1'b0);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule